// File: doc/BRIEF.md
# Bit-Field Insert/Extract Unit

This block works on accumulator-width words (36 bits by default). It moves a contiguous field of bits in three ways. Extraction takes a field out of a source word and right-aligns it. Insertion deposits the low-order bits of a source word at a chosen offset and takes every other bit from a second source word. The third operation is a shuffle with a small bank of alternate accumulators held inside the block. A shuffle stores the source word into the selected alternate and, in the same cycle, returns that alternate's previous content as the result.

The field is described by a 16-bit control word. For each operation the caller picks whether that word comes from an auxiliary register value or from an immediate value. Instruction decode sits outside the block. The caller presents one operation per cycle together with a valid flag. The result appears on a register one clock later.

Top module: `bitfield_unit`

## Requirements
- R1: After reset, `result` is zero and `result_valid` is low. Both alternate accumulators hold zero, so the first shuffle on either one returns zero.
- R2: The field width is control bits 13:8 and the field offset is control bits 5:0. The other control bits are ignored. `ctl_sel`=0 takes the control word from `aux_ctl` and `ctl_sel`=1 takes it from `imm_ctl`.
- R3: With `op_code`=0 (zero-extending extract), result bits below the effective width equal `src_a` bits starting at the offset. All bits above the effective width are zero.
- R4: With `op_code`=1 (sign-extending extract), the low bits are the same as for R3. Every bit from the effective width up through bit 35 equals the top bit of the field.
- R5: With `op_code`=2 (insert), result bits offset..offset+width-1 take `src_a` bits 0..width-1. Every other result bit equals the bit at the same position in `src_b`.
- R6: A width of 0 makes insert return `src_b` unchanged, and makes both extract modes return zero.
- R7: When offset plus width exceeds 36, the field is clipped at bit 35. An offset of 36 or more gives an empty field.
- R8: With `op_code`=3 (shuffle), the result is the value the alternate picked by `alt_sel` held before the operation. That alternate then holds `src_a`. Back-to-back shuffles on the same alternate each see the value written by the previous one.
- R9: `result` and `result_valid` update on the clock edge that samples `op_valid` high. In a cycle without `op_valid`, `result_valid` drops and `result` keeps its value.
- R10: A shuffle changes only the alternate it selects. The other alternate keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 2 | 0 extract zero-ext, 1 extract sign-ext, 2 insert, 3 shuffle |
| ctl_sel | input | 1 | Control word source: 0 auxiliary, 1 immediate |
| aux_ctl | input | 16 | Control word from an auxiliary register |
| imm_ctl | input | 16 | Control word from an immediate |
| src_a | input | 36 | Field source; the value written to an alternate on shuffle |
| src_b | input | 36 | Second source for the bits outside the field on insert |
| alt_sel | input | 1 | Selects the alternate accumulator for a shuffle |
| result | output | 36 | Registered result |
| result_valid | output | 1 | Result was produced by the previous cycle's operation |

## Verification
Random control words cover every width from 0 to 63 and every offset from 0 to 63. Many of these pairs run off the top of the word or start beyond it, so they separate correct clipping from wrap-around or an overflowing mask. Random source words with dense bit patterns tell a correct field position apart from an off-by-one shift. Directed cases set the field's top bit both high and low, which separates sign extension from zero extension. Other directed cases put non-zero junk in the ignored control bits and give the two control sources different values, to show which source was used. Chains of shuffles on both alternates, with other operations in between, show that each alternate keeps its own value and that the swap is single-cycle.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [1:0] {
      BFU_EXTZ    = 2'd0,
      BFU_EXTS    = 2'd1,
      BFU_INSERT  = 2'd2,
      BFU_SHUFFLE = 2'd3
   } bfu_op_e;
endpackage

// File: rtl/bfu_mask_gen.sv
// Builds the clipped field masks from an offset and a requested width.
module bfu_mask_gen #(
   parameter int ACC_W    = 36,
   parameter int FLD_BITS = 6
) (
   input  logic [FLD_BITS-1:0] off,
   input  logic [FLD_BITS-1:0] wid,
   output logic [FLD_BITS:0]   eff_wid,
   output logic [ACC_W-1:0]    place_mask,
   output logic [ACC_W-1:0]    low_mask
);
   localparam int SUM_W = FLD_BITS + 1;
   localparam logic [SUM_W-1:0] ACC_LIM = SUM_W'(ACC_W);

   logic [SUM_W-1:0] off_x;
   logic [SUM_W-1:0] wid_x;
   logic [SUM_W-1:0] end_pos;

   always_comb begin
      off_x   = {1'b0, off};
      wid_x   = {1'b0, wid};
      end_pos = off_x + wid_x;
      if (off_x >= ACC_LIM)
         eff_wid = '0;
      else if (end_pos > ACC_LIM)
         eff_wid = ACC_LIM - off_x;
      else
         eff_wid = wid_x;
   end

   for (genvar i = 0; i < ACC_W; i++) begin : g_bit
      assign place_mask[i] = (SUM_W'(i) >= off_x) && (SUM_W'(i) < end_pos);
      assign low_mask[i]   = (SUM_W'(i) < eff_wid);
   end
endmodule

// File: rtl/bfu_field_path.sv
// Combinational extract and insert datapaths.
module bfu_field_path #(
   parameter int ACC_W       = 36,
   parameter int FLD_BITS    = 6,
   parameter bit SIGN_EXT_EN = 1'b1
) (
   input  logic [ACC_W-1:0]    src_a,
   input  logic [ACC_W-1:0]    src_b,
   input  logic [FLD_BITS-1:0] off,
   input  logic [ACC_W-1:0]    place_mask,
   input  logic [ACC_W-1:0]    low_mask,
   input  logic                sign_mode,
   output logic [ACC_W-1:0]    ext_res,
   output logic [ACC_W-1:0]    ins_res
);
   logic [ACC_W-1:0] shifted;
   logic [ACC_W-1:0] field_lo;
   logic [ACC_W-1:0] top_onehot;
   logic             field_msb;

   always_comb begin
      shifted    = src_a >> off;
      field_lo   = shifted & low_mask;
      // highest set bit of the low mask marks the field's top bit
      top_onehot = low_mask & ~(low_mask >> 1);
      field_msb  = |(shifted & top_onehot);
      ins_res    = (src_b & ~place_mask) | ((src_a << off) & place_mask);
   end

   if (SIGN_EXT_EN) begin : g_sext
      assign ext_res = field_lo | ((sign_mode && field_msb) ? ~low_mask : '0);
   end else begin : g_zext_only
      assign ext_res = field_lo;
   end
endmodule

// File: rtl/bfu_alt_bank.sv
// Alternate accumulators with read-old / write-new swap.
module bfu_alt_bank #(
   parameter int ACC_W = 36,
   parameter int N_ALT = 2,
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] sel,
   input  logic [ACC_W-1:0] wr_data,
   output logic [ACC_W-1:0] rd_data
);
   logic [ACC_W-1:0] alt_q [N_ALT];

   for (genvar g = 0; g < N_ALT; g++) begin : g_alt
      always_ff @(posedge clk) begin
         if (!rst_n)
            alt_q[g] <= '0;
         else if (wr_en && (sel == SEL_W'(g)))
            alt_q[g] <= wr_data;
      end

      // R10
      alt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (sel == SEL_W'(g))) |=> $stable(alt_q[g]));

      // R8
      alt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (sel == SEL_W'(g))) |=> (alt_q[g] == $past(wr_data)));
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < N_ALT; k++)
         if (sel == SEL_W'(k))
            rd_data = alt_q[k];
   end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
   parameter int ACC_W       = 36,
   parameter int CTL_W       = 16,
   parameter int FLD_BITS    = 6,
   parameter int WID_LSB     = 8,
   parameter int OFF_LSB     = 0,
   parameter int N_ALT       = 2,
   parameter bit SIGN_EXT_EN = 1'b1,
   localparam int SEL_W      = (N_ALT > 1) ? $clog2(N_ALT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [1:0]       op_code,
   input  logic             ctl_sel,
   input  logic [CTL_W-1:0] aux_ctl,
   input  logic [CTL_W-1:0] imm_ctl,
   input  logic [ACC_W-1:0] src_a,
   input  logic [ACC_W-1:0] src_b,
   input  logic [SEL_W-1:0] alt_sel,
   output logic [ACC_W-1:0] result,
   output logic             result_valid
);
   import bfu_pkg::*;

   if (ACC_W > (1 << FLD_BITS)) begin : g_bad_fld
      $error("FLD_BITS too small to address ACC_W bits");
   end
   if ((WID_LSB + FLD_BITS > CTL_W) || (OFF_LSB + FLD_BITS > CTL_W)) begin : g_bad_ctl
      $error("control fields do not fit in CTL_W");
   end
   if (N_ALT < 1) begin : g_bad_alt
      $error("N_ALT must be at least 1");
   end

   bfu_op_e           op;
   logic [CTL_W-1:0]  ctl;
   logic [FLD_BITS-1:0] off, wid;
   logic [FLD_BITS:0] eff_wid;
   logic [ACC_W-1:0]  place_mask, low_mask;
   logic [ACC_W-1:0]  ext_res, ins_res, alt_rd;
   logic              shuf_en;
   logic [ACC_W-1:0]  result_q;
   logic              valid_q;

   assign op      = bfu_op_e'(op_code);
   assign ctl     = ctl_sel ? imm_ctl : aux_ctl;
   assign off     = ctl[OFF_LSB +: FLD_BITS];
   assign wid     = ctl[WID_LSB +: FLD_BITS];
   assign shuf_en = op_valid && (op == BFU_SHUFFLE);

   bfu_mask_gen #(.ACC_W(ACC_W), .FLD_BITS(FLD_BITS)) i_mask (
      .off(off), .wid(wid), .eff_wid(eff_wid),
      .place_mask(place_mask), .low_mask(low_mask));

   bfu_field_path #(.ACC_W(ACC_W), .FLD_BITS(FLD_BITS), .SIGN_EXT_EN(SIGN_EXT_EN)) i_path (
      .src_a(src_a), .src_b(src_b), .off(off),
      .place_mask(place_mask), .low_mask(low_mask),
      .sign_mode(op == BFU_EXTS),
      .ext_res(ext_res), .ins_res(ins_res));

   bfu_alt_bank #(.ACC_W(ACC_W), .N_ALT(N_ALT), .SEL_W(SEL_W)) i_alt (
      .clk(clk), .rst_n(rst_n), .wr_en(shuf_en), .sel(alt_sel),
      .wr_data(src_a), .rd_data(alt_rd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= op_valid;
         if (op_valid) begin
            unique case (op)
               BFU_EXTZ, BFU_EXTS: result_q <= ext_res;
               BFU_INSERT:         result_q <= ins_res;
               BFU_SHUFFLE:        result_q <= alt_rd;
               default:            result_q <= ext_res;
            endcase
         end
      end
   end

   assign result       = result_q;
   assign result_valid = valid_q;

   // R7
   mask_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> ($countones(place_mask) == int'(eff_wid)
                    && $countones(low_mask) == int'(eff_wid)));

   // R5
   ins_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (((ins_res ^ src_b) & ~place_mask) == '0));

   // R3
   extz_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == BFU_EXTZ) |=> ((result & ~$past(low_mask)) == '0));

   // R8
   shuffle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shuf_en |=> (result == $past(alt_rd)));

   // R9
   idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !result_valid);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !$past(!rst_n)) |=> $stable(result));
endmodule

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid;
   logic [1:0]  op_code;
   logic        ctl_sel;
   logic [15:0] aux_ctl, imm_ctl;
   logic [35:0] src_a, src_b;
   logic [0:0]  alt_sel;
   logic [35:0] result;
   logic        result_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [35:0] alt_m [2];

   always #4 clk = ~clk;

   bitfield_unit i_bitfield_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .ctl_sel(ctl_sel), .aux_ctl(aux_ctl), .imm_ctl(imm_ctl),
      .src_a(src_a), .src_b(src_b), .alt_sel(alt_sel),
      .result(result), .result_valid(result_valid));

   function automatic logic [35:0] model(logic [1:0] op, logic [15:0] ctl,
                                         logic [35:0] a, logic [35:0] b,
                                         logic [35:0] alt_old);
      int w = int'(ctl[13:8]);
      int o = int'(ctl[5:0]);
      int weff;
      logic [35:0] r = '0;
      weff = (o >= 36) ? 0 : ((o + w > 36) ? 36 - o : w);
      if (op == 2'd3) return alt_old;
      if (op == 2'd2) begin
         for (int i = 0; i < 36; i++)
            r[i] = (i >= o && i < o + weff) ? a[i - o] : b[i];
         return r;
      end
      for (int i = 0; i < weff; i++) r[i] = a[i + o];
      if (op == 2'd1 && weff > 0)
         for (int i = weff; i < 36; i++) r[i] = a[o + weff - 1];
      return r;
   endfunction

   task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(string req, logic [1:0] op, logic sel,
                         logic [15:0] aux, logic [15:0] imm,
                         logic [35:0] a, logic [35:0] b, logic asel);
      logic [35:0] exp;
      @(negedge clk);
      op_valid = 1'b1; op_code = op; ctl_sel = sel;
      aux_ctl = aux; imm_ctl = imm; src_a = a; src_b = b; alt_sel = asel;
      exp = model(op, sel ? imm : aux, a, b, alt_m[asel]);
      if (op == 2'd3) alt_m[asel] = a;
      @(negedge clk);
      op_valid = 1'b0;
      chk(req, result, exp);
      chk({req, " R9 valid"}, {35'd0, result_valid}, 36'd1);
   endtask

   function automatic logic [15:0] mk(int w, int o);
      return {2'b00, 6'(w), 2'b00, 6'(o)};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [35:0] held;
      void'($urandom(32'h5EED_0042));
      alt_m[0] = '0; alt_m[1] = '0;
      rst_n = 1'b0; op_valid = 1'b0; op_code = '0; ctl_sel = 1'b0;
      aux_ctl = '0; imm_ctl = '0; src_a = '0; src_b = '0; alt_sel = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 result", result, '0);
      chk("R1 valid", {35'd0, result_valid}, '0);
      rst_n = 1'b1;
      // R1 alternates cleared (R8 swap)
      run_op("R1 alt0", 2'd3, 1'b0, 16'h0, 16'h0, 36'h1_2345_6789, '0, 1'b0);
      run_op("R1 alt1", 2'd3, 1'b0, 16'h0, 16'h0, 36'hA_BCDE_F012, '0, 1'b1);
      // R8 back-to-back on one alternate, R10 other untouched
      run_op("R8 chain", 2'd3, 1'b0, 16'h0, 16'h0, 36'h5_5555_0000, '0, 1'b0);
      run_op("R8 chain2", 2'd3, 1'b0, 16'h0, 16'h0, 36'h0_0000_0001, '0, 1'b0);
      run_op("R10 alt1 kept", 2'd3, 1'b0, 16'h0, 16'h0, 36'hF_0000_000F, '0, 1'b1);
      // R3 basic extract
      run_op("R3 extz", 2'd0, 1'b0, mk(8, 4), 16'h0, 36'h0_0000_0AB0, '0, 1'b0);
      // R4 sign extension, top bit high and low
      run_op("R4 exts neg", 2'd1, 1'b0, mk(8, 4), 16'h0, 36'h0_0000_0AB0, '0, 1'b0);
      run_op("R4 exts pos", 2'd1, 1'b0, mk(8, 4), 16'h0, 36'h0_0000_07B0, '0, 1'b0);
      // R5 insert
      run_op("R5 insert", 2'd2, 1'b0, mk(12, 20), 16'h0, 36'h0_0000_0ABC, 36'hF_FFFF_FFFF, 1'b0);
      // R6 width zero
      run_op("R6 ins w0", 2'd2, 1'b0, mk(0, 7), 16'h0, 36'hF_FFFF_FFFF, 36'h3_1415_9265, 1'b0);
      run_op("R6 ext w0", 2'd1, 1'b0, mk(0, 7), 16'h0, 36'hF_FFFF_FFFF, '0, 1'b0);
      // R7 clipping and empty field
      run_op("R7 clip ext", 2'd1, 1'b0, mk(10, 30), 16'h0, 36'h8_0000_0000, '0, 1'b0);
      run_op("R7 clip ins", 2'd2, 1'b0, mk(63, 30), 16'h0, 36'hF_FFFF_FFFF, '0, 1'b0);
      run_op("R7 off36", 2'd0, 1'b0, mk(5, 36), 16'h0, 36'hF_FFFF_FFFF, '0, 1'b0);
      run_op("R7 off63 ins", 2'd2, 1'b0, mk(63, 63), 16'h0, 36'hF_FFFF_FFFF, 36'h1, 1'b0);
      // R2 source select and ignored control bits
      run_op("R2 imm", 2'd0, 1'b1, mk(4, 0), mk(4, 8) | 16'hC0C0, 36'h0_0000_0F5A, '0, 1'b0);
      run_op("R2 aux", 2'd0, 1'b0, mk(4, 0) | 16'hC0C0, mk(4, 8), 36'h0_0000_0F5A, '0, 1'b0);
      // R9 idle hold
      held = result;
      @(negedge clk);
      chk("R9 idle valid", {35'd0, result_valid}, '0);
      chk("R9 idle hold", result, held);
      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [1:0]  rop = 2'($urandom);
         logic        rsel = 1'($urandom);
         logic [15:0] ra = 16'($urandom);
         logic [15:0] rb = 16'($urandom);
         logic [35:0] da = {4'($urandom), 32'($urandom)};
         logic [35:0] db = {4'($urandom), 32'($urandom)};
         case (rop)
            2'd0: run_op("R3 rand", rop, rsel, ra, rb, da, db, 1'($urandom));
            2'd1: run_op("R4 rand", rop, rsel, ra, rb, da, db, 1'($urandom));
            2'd2: run_op("R5 rand", rop, rsel, ra, rb, da, db, 1'($urandom));
            default: run_op("R8 rand", rop, rsel, ra, rb, da, db, 1'($urandom));
         endcase
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule